// File: doc/BRIEF.md
# Johnson-Ring Time Digit Slice

This block is one two-digit stage of a digital time-of-day counter. The units digit is a five-flop twisted shift register, which walks through ten states. The tens digit is a three-flop register. A strap input sets how it is wired. As a twisted register it walks six states, so the slice counts 00 to 59 for seconds or minutes. As a plain rotating ring it walks three states, for hours. Each digit drives a one-hot line per lit LED, so no binary-to-decimal decoder is needed.

In hours mode the slice records that it has just reached 23. On the next enabled clock it reloads both digits to their reset patterns, so 24 is never shown. Every wrap to 00 raises a carry for exactly one cycle. The carry feeds the count enable of the next slice. The count enable gates every state change.

Top module: `jts_time_slice`

## Requirements
- R1: The units digit steps one state per enabled clock through the ten states 0..9 and returns to 0 after 9. `lo_led_o` bit k is high in state k.
- R2: At any time outside reset, exactly one bit of `lo_led_o` is high and exactly one bit of `hi_led_o` is high.
- R3: While `rst_ni` is low, the slice shows 00 at once, without waiting for a clock. That means `lo_led_o` = 10'b0000000001, `hi_led_o` = 6'b000001 and `carry_o` = 0.
- R4: With `hours_mode_i` = 0, the tens digit advances only on an enabled clock where the units digit is at 9. It walks the states 0..5, so the slice repeats every 60 enabled clocks.
- R5: With `hours_mode_i` = 1, the tens digit walks the states 0, 1, 2, and `hi_led_o[5:3]` stays 0.
- R6: With `hours_mode_i` = 1, the first enabled clock after the slice reaches 23 returns it to 00. The display never shows 24.
- R7: `carry_o` is high for exactly the one cycle after the clock that wraps the slice to 00, and the display shows 00 during that cycle. It is low at all other times.
- R8: While `en_i` is low, both digits hold their value.
- R9: In hours mode, the recorded 23 persists across any number of disabled cycles. The slice stays at 23 until the next enabled clock wraps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable, one step per high clock |
| hours_mode_i | input | 1 | Strap: 0 counts 60, 1 counts 24 |
| lo_led_o | output | 10 | One-hot units digit |
| hi_led_o | output | 6 | One-hot tens digit |
| carry_o | output | 1 | One-cycle pulse after the wrap to 00 |

## Verification
In hours mode, the latched 23 terminal reload and the ordinary units-digit advance compete for the same enabled edge. The tens-digit advance at 9 is the third candidate. The bench drives the slice to 23, holds the enable low for a few cycles and then gives one enabled clock. It expects 00 with the carry high rather than 24. It repeats this on two full 24-hour laps, where the reload edge follows the 09 and 19 tens carries. All values are compared against a separate step model in the bench.

// File: rtl/jts_pkg.sv
package jts_pkg;
  typedef enum logic {
    FMT_SEXAGESIMAL = 1'b0,
    FMT_HOURS       = 1'b1
  } fmt_e;
endpackage

// File: rtl/jts_johnson_digit.sv
module jts_johnson_digit #(
  parameter int N = 5,
  localparam int W = 2 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         clr_i,
  output logic [W-1:0] led_o,
  output logic         last_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (clr_i)  q <= '0;
    else if (adv_i)  q <= {q[N-2:0], ~q[N-1]};
  end

  // state k is marked by the position of the single 0/1 boundary
  for (genvar k = 0; k < W; k++) begin : g_dec
    if (k == 0) begin : g_z
      assign led_o[k] = ~q[N-1] & ~q[0];
    end else if (k < N) begin : g_fill
      assign led_o[k] = q[k-1] & ~q[k];
    end else if (k == N) begin : g_full
      assign led_o[k] = q[N-1] & q[0];
    end else begin : g_drain
      assign led_o[k] = ~q[k-N-1] & q[k-N];
    end
  end

  assign last_o = q[N-1] & ~q[N-2];
endmodule

// File: rtl/jts_upper_digit.sv
module jts_upper_digit #(
  parameter int N = 3,
  localparam int W = 2 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ring_i,
  input  logic         adv_i,
  input  logic         clr_i,
  output logic [W-1:0] led_o,
  output logic         last_o
);
  logic [N-1:0] q;
  logic [N-1:0] rst_pat;
  logic [N-1:0] nxt;
  logic [W-1:0] dec_tw;
  logic [W-1:0] dec_rg;

  // ring starts with a single 1 at the top bit, twisted starts empty
  assign rst_pat = ring_i ? {1'b1, {(N-1){1'b0}}} : '0;
  assign nxt     = {q[N-2:0], ring_i ? q[N-1] : ~q[N-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= rst_pat;
    else if (clr_i)  q <= rst_pat;
    else if (adv_i)  q <= nxt;
  end

  for (genvar k = 0; k < W; k++) begin : g_dec
    if (k == 0) begin : g_z
      assign dec_tw[k] = ~q[N-1] & ~q[0];
      assign dec_rg[k] = q[N-1];
    end else if (k < N) begin : g_fill
      assign dec_tw[k] = q[k-1] & ~q[k];
      assign dec_rg[k] = q[k-1];
    end else if (k == N) begin : g_full
      assign dec_tw[k] = q[N-1] & q[0];
      assign dec_rg[k] = 1'b0;
    end else begin : g_drain
      assign dec_tw[k] = ~q[k-N-1] & q[k-N];
      assign dec_rg[k] = 1'b0;
    end
  end

  assign led_o  = ring_i ? dec_rg : dec_tw;
  assign last_o = ring_i ? q[N-2] : (q[N-1] & ~q[N-2]);
endmodule

// File: rtl/jts_wrap_ctrl.sv
module jts_wrap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hours_i,
  input  logic lo_last_i,
  input  logic hi_last_i,
  input  logic at_pre_i,
  output logic lo_adv_o,
  output logic hi_adv_o,
  output logic clr_o,
  output logic carry_o
);
  logic pend_q;
  logic wrap_60;
  logic carry_q;

  assign clr_o    = en_i & pend_q;
  assign lo_adv_o = en_i & ~pend_q;
  assign hi_adv_o = en_i & ~pend_q & lo_last_i;
  assign wrap_60  = en_i & ~hours_i & lo_last_i & hi_last_i;

  // pend_q marks "showing the last hour", set on the step into it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (!hours_i)        pend_q <= 1'b0;
      else if (clr_o)      pend_q <= 1'b0;
      else if (en_i && at_pre_i) pend_q <= 1'b1;
      carry_q <= clr_o | wrap_60;
    end
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/jts_time_slice.sv
module jts_time_slice
  import jts_pkg::*;
#(
  parameter int LO_STAGES = 5,
  parameter int HI_STAGES = 3,
  parameter int HRS_TENS  = 2,
  parameter int HRS_UNITS = 3,
  localparam int LO_W = 2 * LO_STAGES,
  localparam int HI_W = 2 * HI_STAGES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            hours_mode_i,
  output logic [LO_W-1:0] lo_led_o,
  output logic [HI_W-1:0] hi_led_o,
  output logic            carry_o
);
  logic hours;
  logic lo_last, hi_last, at_pre;
  logic lo_adv, hi_adv, clr;

  assign hours  = (fmt_e'(hours_mode_i) == FMT_HOURS);
  assign at_pre = hi_led_o[HRS_TENS] & lo_led_o[HRS_UNITS-1];

  jts_johnson_digit #(.N(LO_STAGES)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (lo_adv),
    .clr_i  (clr),
    .led_o  (lo_led_o),
    .last_o (lo_last)
  );

  jts_upper_digit #(.N(HI_STAGES)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ring_i (hours),
    .adv_i  (hi_adv),
    .clr_i  (clr),
    .led_o  (hi_led_o),
    .last_o (hi_last)
  );

  jts_wrap_ctrl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .hours_i   (hours),
    .lo_last_i (lo_last),
    .hi_last_i (hi_last),
    .at_pre_i  (at_pre),
    .lo_adv_o  (lo_adv),
    .hi_adv_o  (hi_adv),
    .clr_o     (clr),
    .carry_o   (carry_o)
  );
endmodule

// File: rtl/jts_time_slice_chk.sv
module jts_time_slice_chk #(
  parameter int LO_W = 10,
  parameter int HI_W = 6,
  parameter int HRS_TENS = 2,
  parameter int HRS_UNITS = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            hours_mode_i,
  input logic [LO_W-1:0] lo_led_o,
  input logic [HI_W-1:0] hi_led_o,
  input logic            carry_o
);
  p_lo_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lo_led_o) == 1);

  p_hi_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hi_led_o) == 1);

  p_carry_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> !carry_o);

  p_carry_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (lo_led_o[0] && hi_led_o[0]));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(lo_led_o) && $stable(hi_led_o)));

  p_no_24_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hours_mode_i |-> !(hi_led_o[HRS_TENS] && lo_led_o[HRS_UNITS+1]));

  p_hrs_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hours_mode_i |-> (hi_led_o[HI_W-1:3] == '0));

  p_tens_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hours_mode_i && $past(!hours_mode_i) && hi_led_o != $past(hi_led_o))
      |-> ($past(lo_led_o[LO_W-1]) && $past(en_i)));
endmodule

bind jts_time_slice jts_time_slice_chk #(
  .LO_W(LO_W), .HI_W(HI_W), .HRS_TENS(HRS_TENS), .HRS_UNITS(HRS_UNITS)
) u_chk (.*);

// File: tb/jts_time_slice_tb.sv
module jts_time_slice_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       hours_mode_i = 1'b0;
  logic [9:0] lo_led_o;
  logic [5:0] hi_led_o;
  logic       carry_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_lo, m_hi, m_c;

  always #5 clk_i = ~clk_i;

  jts_time_slice u_dut (.*);

  typedef struct packed {
    logic       rst;
    logic       hrs;
    logic       en;
    logic [7:0] n;
    logic [3:0] lo;
    logic [2:0] hi;
    logic       c;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 8'd0,  4'd0, 3'd0, 1'b0}, // R3 reset, 60 mode
    '{1'b0, 1'b0, 1'b1, 8'd9,  4'd9, 3'd0, 1'b0}, // R1
    '{1'b0, 1'b0, 1'b1, 8'd1,  4'd0, 3'd1, 1'b0}, // R4
    '{1'b0, 1'b0, 1'b0, 8'd5,  4'd0, 3'd1, 1'b0}, // R8
    '{1'b0, 1'b0, 1'b1, 8'd49, 4'd9, 3'd5, 1'b0}, // R4 at 59
    '{1'b0, 1'b0, 1'b1, 8'd1,  4'd0, 3'd0, 1'b1}, // R7 wrap
    '{1'b0, 1'b0, 1'b1, 8'd1,  4'd1, 3'd0, 1'b0}, // R7 one cycle
    '{1'b1, 1'b1, 1'b0, 8'd0,  4'd0, 3'd0, 1'b0}, // R3 reset, hours
    '{1'b0, 1'b1, 1'b1, 8'd13, 4'd3, 3'd1, 1'b0}, // R5
    '{1'b0, 1'b1, 1'b1, 8'd9,  4'd2, 3'd2, 1'b0}, // R5 at 22
    '{1'b0, 1'b1, 1'b1, 8'd1,  4'd3, 3'd2, 1'b0}, // R6 at 23
    '{1'b0, 1'b1, 1'b0, 8'd4,  4'd3, 3'd2, 1'b0}, // R9 held
    '{1'b0, 1'b1, 1'b1, 8'd1,  4'd0, 3'd0, 1'b1}, // R6 wrap
    '{1'b0, 1'b1, 1'b1, 8'd1,  4'd1, 3'd0, 1'b0}, // R7
    '{1'b0, 1'b1, 1'b1, 8'd9,  4'd0, 3'd1, 1'b0}  // R5 at 10
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic hrs);
    @(negedge clk_i);
    hours_mode_i = hrs;
    en_i = 1'b0;
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_lo = 0; m_hi = 0; m_c = 0;
  endtask

  task automatic tick(input logic en);
    @(negedge clk_i);
    en_i = en;
    @(posedge clk_i);
    #2;
    chk($countones(lo_led_o) == 1, "R2 lo", int'(lo_led_o), 1);
    chk($countones(hi_led_o) == 1, "R2 hi", int'(hi_led_o), 1);
  endtask

  function automatic void model(input logic en, input logic hrs);
    m_c = 0;
    if (!en) return;
    if (hrs && m_hi == 2 && m_lo == 3) begin
      m_lo = 0; m_hi = 0; m_c = 1;
    end else begin
      m_lo++;
      if (m_lo == 10) begin
        m_lo = 0;
        m_hi++;
        if (!hrs && m_hi == 6) begin m_hi = 0; m_c = 1; end
      end
    end
  endfunction

  task automatic cmp_model(input string req);
    chk(lo_led_o == 10'(1 << m_lo), req, int'(lo_led_o), 1 << m_lo);
    chk(hi_led_o == 6'(1 << m_hi), req, int'(hi_led_o), 1 << m_hi);
    chk(carry_o == m_c[0], req, int'(carry_o), m_c);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    // table walk
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].rst) do_reset(VECS[v].hrs);
      for (int s = 0; s < int'(VECS[v].n); s++) tick(VECS[v].en);
      #1;
      chk(lo_led_o == 10'(1 << VECS[v].lo), "R1/R3/R6 lo", int'(lo_led_o), 1 << VECS[v].lo);
      chk(hi_led_o == 6'(1 << VECS[v].hi), "R4/R5/R9 hi", int'(hi_led_o), 1 << VECS[v].hi);
      chk(carry_o == VECS[v].c, "R7 carry", int'(carry_o), int'(VECS[v].c));
    end

    // R4 R1 R7: two full 60 laps against the step model
    do_reset(1'b0);
    for (int i = 0; i < 120; i++) begin
      tick(1'b1);
      model(1'b1, 1'b0);
      cmp_model("R4");
    end

    // R5 R6 R7: two full 24 laps with idle gaps
    do_reset(1'b1);
    for (int i = 0; i < 60; i++) begin
      logic e;
      e = (i % 5) != 4;
      tick(e);
      model(e, 1'b1);
      cmp_model("R6");
      chk(hi_led_o[5:3] == 3'b000, "R5", int'(hi_led_o), 0);
    end

    // R3: asynchronous reset mid-count
    for (int i = 0; i < 17; i++) tick(1'b1);
    @(posedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    chk(lo_led_o == 10'b1, "R3 async lo", int'(lo_led_o), 1);
    chk(hi_led_o == 6'b1, "R3 async hi", int'(hi_led_o), 1);
    chk(carry_o == 1'b0, "R3 async carry", int'(carry_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule